// File: doc/BRIEF.md
# Bit-Bang I2C Register Port

This peripheral lets software run an I2C bus by hand. Software toggles the clock and data lines one step at a time through a small register window, and the block drives both lines open-drain. A line held at logic 1 is released to the external pull-up. A line at logic 0 is pulled low. The data line the bus actually carries passes through a synchronizer and comes back as a status bit, so software can read acknowledge and data bits from a target.

The register bus is a plain single-cycle port. An access takes place in any cycle where `reg_en` is high, and `reg_we` selects a write or a read. Read data and the error flag are combinational in the cycle of the access, so the port has no back-pressure and no wait states. The window is 4 KB wide and holds only a few valid offsets:

- A write to offset 0x0 sets line bits.
- A write to offset 0x4 clears line bits.
- A read of offset 0x0 returns status.
- Every other access is flagged as an error.

Line bit 0 is the clock line (SCL) and line bit 1 is the data line (SDA).

Top module: `i2c_bitbang_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, both line bits become 1. Both enables (`scl_oe`, `sda_oe`) are then low and the bus is released. The synchronizer stages also reset to 1.
- R2: A write to offset 0x0 sets line bit k wherever `reg_wdata[k]` is 1, for k in {0,1}. Bits 31:2 of the write data have no effect. The new level shows on the pads after the next clock edge.
- R3: A write to offset 0x4 clears line bit k wherever `reg_wdata[k]` is 1, for k in {0,1}. Bits 31:2 have no effect.
- R4: The lines are open-drain. `scl_oe` is the inverse of line bit 0 and `sda_oe` is the inverse of line bit 1. `scl_o` and `sda_o` are always 0.
- R5: A read of offset 0x0 has no error. It returns the driven SCL level in bit 0 and the synchronized SDA input in bit 1. Bits 31:2 read as 0.
- R6: A bad access raises `reg_err` in the same cycle. A bad access is a read of any offset other than 0x0, or a write to any offset other than 0x0 and 0x4, misaligned offsets included. A bad read returns 0xFFFFFFFF. A bad write leaves both line bits unchanged.
- R7: `reg_err` stays low on valid accesses and in cycles without an access.
- R8: The SDA input passes through a two-flop synchronizer. A change on `sda_i` is still hidden after one rising edge and shows in status bit 1 after the second rising edge.
- R9: With `reg_en` low, the line bits hold whatever `reg_we`, `reg_addr` and `reg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset within the 4 KB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| reg_err | output | 1 | Bad-offset pulse, in the access cycle |
| scl_i | input | 1 | Clock line as seen at the pad |
| sda_i | input | 1 | Data line as seen at the pad |
| scl_o | output | 1 | Clock pad output value (always 0) |
| sda_o | output | 1 | Data pad output value (always 0) |
| scl_oe | output | 1 | Clock pull-down enable |
| sda_oe | output | 1 | Data pull-down enable |

## Verification
The checker watches several properties on every cycle:

- Both pad outputs stay at zero.
- A bad write or an idle cycle leaves the pull-down enables unchanged.
- A bad read returns all ones.
- A valid status read has zero upper bits and a clock bit equal to the inverse of `scl_oe`.
- A set or clear write moves the selected enable on the following edge.

The bench scenarios are needed for three things. They confirm the exact two-edge synchronizer latency on the data input. They confirm the value of the returned data bit while the bus is held low externally. They confirm the reset behaviour after traffic.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned LINE_W   = 2;
  localparam int unsigned SCL_BIT  = 0;
  localparam int unsigned SDA_BIT  = 1;
  localparam logic [ADDR_W-1:0] OFS_SET = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CLR = 12'h004;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SET,
    ACC_CLR,
    ACC_STAT
  } acc_kind_e;
endpackage

// File: rtl/i2cbb_sync.sv
module i2cbb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) chain[w] <= {STAGES{RST_VAL}};
      else        chain[w] <= {chain[w][STAGES-2:0], din[w]};
    end
    assign dout[w] = chain[w][STAGES-1];
  end
endmodule

// File: rtl/i2cbb_decode.sv
module i2cbb_decode
  import i2cbb_pkg::*;
(
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LINE_W-1:0] status,
  output logic [LINE_W-1:0] set_mask,
  output logic [LINE_W-1:0] clr_mask,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  acc_kind_e kind;
  logic      unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:LINE_W];

  always_comb begin
    kind = ACC_NONE;
    err  = 1'b0;
    if (en) begin
      if (we && addr == OFS_SET)       kind = ACC_SET;
      else if (we && addr == OFS_CLR)  kind = ACC_CLR;
      else if (!we && addr == OFS_SET) kind = ACC_STAT;
      else                             err  = 1'b1;
    end
  end

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    rdata    = '0;
    unique case (kind)
      ACC_SET:  set_mask = wdata[LINE_W-1:0];
      ACC_CLR:  clr_mask = wdata[LINE_W-1:0];
      ACC_STAT: rdata[LINE_W-1:0] = status;
      default:  ;
    endcase
    if (err && !we) rdata = '1;
  end
endmodule

// File: rtl/i2cbb_lines.sv
module i2cbb_lines
  import i2cbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] set_mask,
  input  logic [LINE_W-1:0] clr_mask,
  output logic [LINE_W-1:0] level
);
  always_ff @(posedge clk) begin
    if (!rst_n) level <= '1;
    else        level <= (level | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/i2c_bitbang_port.sv
module i2c_bitbang_port
  import i2cbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_err,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic [LINE_W-1:0] set_mask, clr_mask, level, pads_sync, status;
  logic              unused_scl_sync;

  i2cbb_decode u_dec (
    .en(reg_en), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .set_mask(set_mask), .clr_mask(clr_mask),
    .rdata(reg_rdata), .err(reg_err)
  );

  i2cbb_lines u_lines (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .level(level)
  );

  i2cbb_sync #(.WIDTH(LINE_W), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sda_i, scl_i}), .dout(pads_sync)
  );

  assign unused_scl_sync = pads_sync[SCL_BIT];
  assign status[SCL_BIT] = level[SCL_BIT];
  assign status[SDA_BIT] = pads_sync[SDA_BIT];

  assign scl_o  = 1'b0;
  assign sda_o  = 1'b0;
  assign scl_oe = ~level[SCL_BIT];
  assign sda_oe = ~level[SDA_BIT];
endmodule

// File: rtl/i2c_bitbang_port_chk.sv
module i2c_bitbang_port_chk
  import i2cbb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_err,
  input logic              scl_o,
  input logic              sda_o,
  input logic              scl_oe,
  input logic              sda_oe
);
  // R4
  od_low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_o && !sda_o);

  // R6
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && reg_we && reg_err |=> $stable(scl_oe) && $stable(sda_oe));

  // R6
  bad_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && !reg_we && reg_err |-> reg_rdata == '1);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |=> $stable(scl_oe) && $stable(sda_oe));

  // R5
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && !reg_we && reg_addr == OFS_SET |->
      !reg_err && reg_rdata[DATA_W-1:2] == '0 && reg_rdata[0] == !scl_oe);

  // R7
  no_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> !reg_err);

  // R2
  set_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && reg_we && reg_addr == OFS_SET && reg_wdata[0] |=> !scl_oe);

  // R3
  clr_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en && reg_we && reg_addr == OFS_CLR && reg_wdata[1] |=> sda_oe);
endmodule

bind i2c_bitbang_port i2c_bitbang_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_err(reg_err), .scl_o(scl_o), .sda_o(sda_o),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/sim_i2c_bitbang_port.sv
module sim_i2c_bitbang_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        scl_o, sda_o, scl_oe, sda_oe;
  logic        sda_ext = 1'b1;
  logic        scl_i, sda_i;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign scl_i = ~scl_oe;
  assign sda_i = sda_oe ? 1'b0 : sda_ext;

  i2c_bitbang_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .scl_i(scl_i), .sda_i(sda_i), .scl_o(scl_o),
    .sda_o(sda_o), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // vector: we | addr | wdata | exp_err | exp_rdata | exp_lines{sda,scl}
  localparam int NV = 13;
  localparam logic [79:0] VEC [NV] = '{
    {1'b1, 12'h004, 32'h0000_0001, 1'b0, 32'h0, 2'b10},
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h2, 2'b10},
    {1'b1, 12'h004, 32'hFFFF_FFFE, 1'b0, 32'h0, 2'b00},
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h0, 2'b00},
    {1'b1, 12'h000, 32'hFFFF_FFFD, 1'b0, 32'h0, 2'b01},
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h1, 2'b01},
    {1'b1, 12'h008, 32'h0000_0003, 1'b1, 32'h0, 2'b01},
    {1'b0, 12'h004, 32'h0,         1'b1, 32'hFFFF_FFFF, 2'b01},
    {1'b1, 12'h000, 32'h0000_0002, 1'b0, 32'h0, 2'b11},
    {1'b0, 12'h000, 32'h0,         1'b0, 32'h3, 2'b11},
    {1'b1, 12'h002, 32'h0000_0003, 1'b1, 32'h0, 2'b11},
    {1'b1, 12'hFFC, 32'h0000_0003, 1'b1, 32'h0, 2'b11},
    {1'b0, 12'hFF0, 32'h0,         1'b1, 32'hFFFF_FFFF, 2'b11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_en = 1'b0;
    end
  endtask

  task automatic check_lines(input string req, input logic [1:0] lines);
    chk(req, {30'b0, ~sda_oe, ~scl_oe}, {30'b0, lines});
    chk("R4", {30'b0, sda_o, scl_o}, 32'h0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check_lines("R1", 2'b11);
    chk("R7", {31'b0, reg_err}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      reg_en    = 1'b1;
      reg_we    = VEC[v][79];
      reg_addr  = VEC[v][78:67];
      reg_wdata = VEC[v][66:35];
      #1;
      // R6 R7 error pulse in the access cycle
      chk(VEC[v][34] ? "R6" : "R7", {31'b0, reg_err}, {31'b0, VEC[v][34]});
      if (!VEC[v][79]) chk("R5/R6 read", reg_rdata, VEC[v][33:2]);
      idle(3);
      #1;
      check_lines(VEC[v][34] ? "R6 hold" : "R2/R3", VEC[v][1:0]);
    end

    // R8: external low on released SDA takes two edges
    @(negedge clk);
    sda_ext = 1'b0;
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 12'h000;
    @(negedge clk); #1;
    chk("R8 one edge", reg_rdata, 32'h3);
    @(negedge clk); #1;
    chk("R8 two edges", reg_rdata, 32'h1);
    sda_ext = 1'b1;
    idle(3);

    // R9: disabled strobe ignores a clearing write
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h3;
    @(negedge clk); #1;
    check_lines("R9", 2'b11);
    chk("R7 idle", {31'b0, reg_err}, 32'h0);

    // R3 both bits cleared in one write, then R1 reset restores release
    reg_en = 1'b1;
    @(negedge clk); #1;
    reg_en = 1'b0;
    check_lines("R3", 2'b00);
    rst_n = 1'b0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    check_lines("R1 after traffic", 2'b11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule